// File: doc/BRIEF.md
# Serial Three-Wire EEPROM Slave Controller

This block is a cycle-based model of the control logic of a small serial EEPROM that answers on a Microwire bus. It is a 64-word by 16-bit store. A fast system clock samples the bus lines chip select, serial clock and serial data in. The block detects edges on them and shifts each frame through a bit sequencer. At each chip-select falling edge it acts on the completed frame. The storage array is a register file inside the block. The serial output is modelled as a data bit plus an output enable, and the enable stands in for the high-impedance state.

A frame is made of a start bit, a two-bit opcode and a six-bit address. Write-type commands then carry sixteen data bits. Reads return a zero dummy bit and then the word. The programming commands are gated by a write-enable latch and run for a self-timed interval counted in system clocks. During that interval the serial output reports busy or ready whenever chip select is high. A ready indication stays on the line until the master clocks in a new start bit, and that start bit may also open the next command.

Top module: `mw_eeprom_slave`

## Requirements
- R1: A frame is a 1 start bit, then opcode bits op1 op0, then address bits A5..A0, all MSB first. Any 0 bits before the start bit are skipped. Opcode 10 is READ, 01 is WRITE and 11 is ERASE. Opcode 00 is decoded by A5:A4: 11 enables writes, 00 disables writes, 01 writes all words and 10 erases all words.
- R2: DI is sampled and DO is updated on serial clock rising edges. A READ drives a 0 dummy bit from the rising edge that takes A0, then data bits 15 down to 0 on the following rising edges.
- R3: After reset the block is write-disabled, every word holds 0 and the output enable is low.
- R4: Enable and disable take effect when chip select falls at the end of their frame. While the block is disabled, the four programming commands change nothing.
- R5: WRITE takes 16 data bits, MSB first, and stores them at the addressed word when chip select falls after the last data bit.
- R6: ERASE sets the addressed word to 0xFFFF, erase-all sets every word to 0xFFFF, and write-all loads its 16-bit value into every word.
- R7: An accepted programming command keeps the block busy for PROG_CYCLES system clocks. While chip select is high after it, DO shows 0 while busy and 1 when done, with no serial clock needed, and toggling chip select does not disturb the cycle.
- R8: The output enable is low whenever chip select is low.
- R9: A start bit removes the ready indication, and the same start bit begins the next command.
- R10: Frames that arrive while programming is running are ignored.
- R11: No programming starts if chip select falls before a frame is complete, or after extra serial clock edges have followed a complete programming frame.
- R12: READ works whether or not writes are enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, much faster than the serial clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_i | input | 1 | Chip select, active high, asynchronous to clk_i |
| sk_i | input | 1 | Serial clock from the bus master |
| di_i | input | 1 | Serial data from the master |
| do_o | output | 1 | Serial data or status bit to the master |
| do_oe_o | output | 1 | Output enable for do_o; low means high impedance |

## Verification
One serial clock edge can do two jobs at once: the start bit that clears the ready status is also the first bit of a new READ. The bench provokes this by waiting with chip select high until DO shows ready. It then clocks in a READ frame in the same chip-select period. It checks that the output enable drops after the start bit, that the dummy bit follows, and that the word written just before comes back. A second overlap happens when a new frame arrives while the programming counter is still running. That frame must be ignored, and a later read of the target word shows whether it was.

// File: rtl/mw_pkg.sv
package mw_pkg;

  typedef enum logic [2:0] {
    CMD_NONE, CMD_READ, CMD_WRITE, CMD_ERASE,
    CMD_WEN, CMD_WDS, CMD_WRALL, CMD_ERALL
  } cmd_e;

  typedef enum logic [2:0] {
    SEQ_IDLE, SEQ_HDR, SEQ_DATA, SEQ_RD, SEQ_DONE, SEQ_OVER
  } seq_e;

  function automatic cmd_e decode_cmd(input logic [1:0] op, input logic [1:0] ext);
    cmd_e c;
    unique case (op)
      2'b10: c = CMD_READ;
      2'b01: c = CMD_WRITE;
      2'b11: c = CMD_ERASE;
      default: begin
        unique case (ext)
          2'b11:   c = CMD_WEN;
          2'b00:   c = CMD_WDS;
          2'b01:   c = CMD_WRALL;
          default: c = CMD_ERALL;
        endcase
      end
    endcase
    return c;
  endfunction

endpackage

// File: rtl/mw_sync_edge.sv
module mw_sync_edge #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] raw_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] rise_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic s1_q, s2_q, s3_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
        s3_q <= 1'b0;
      end else begin
        s1_q <= raw_i[g];
        s2_q <= s1_q;
        s3_q <= s2_q;
      end
    end
    assign lvl_o[g]  = s2_q;
    assign rise_o[g] = s2_q & ~s3_q;
  end
endmodule

// File: rtl/mw_frame_dec.sv
module mw_frame_dec
  import mw_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_i,
  input  logic          sk_rise_i,
  input  logic          di_i,
  input  logic          busy_i,
  input  logic [DW-1:0] rd_word_i,
  output logic [AW-1:0] rd_addr_o,
  output logic          start_o,
  output logic          exec_o,
  output cmd_e          cmd_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] data_o,
  output logic          rd_act_o,
  output logic          rd_bit_o
);
  localparam int HW   = AW + 2;
  localparam int MAXB = (DW > HW) ? DW : HW;
  localparam int CW   = $clog2(MAXB);

  seq_e          state_q;
  logic [CW-1:0] cnt_q;
  logic [HW-1:0] hdr_q;
  logic [DW-1:0] data_q;
  logic [DW:0]   rd_sr_q;
  logic          start_q, exec_q;
  cmd_e          cmd_q;
  logic [AW-1:0] addr_q;

  logic [HW-1:0] hdr_nx;
  cmd_e          cmd_nx;
  assign hdr_nx    = {hdr_q[HW-2:0], di_i};
  assign cmd_nx    = decode_cmd(hdr_nx[HW-1:HW-2], hdr_nx[AW-1:AW-2]);
  assign rd_addr_o = hdr_nx[AW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
      hdr_q   <= '0;
      data_q  <= '0;
      rd_sr_q <= '0;
      start_q <= 1'b0;
      exec_q  <= 1'b0;
      cmd_q   <= CMD_NONE;
      addr_q  <= '0;
    end else begin
      start_q <= 1'b0;
      exec_q  <= 1'b0;
      if (!cs_i) begin
        // frame ends: act only on a frame that stopped exactly at its last bit
        if (state_q == SEQ_DONE) exec_q <= 1'b1;
        state_q <= SEQ_IDLE;
        cnt_q   <= '0;
        rd_sr_q <= '0;
      end else if (sk_rise_i) begin
        unique case (state_q)
          SEQ_IDLE: if (di_i && !busy_i) begin
            start_q <= 1'b1;
            state_q <= SEQ_HDR;
            cnt_q   <= '0;
          end
          SEQ_HDR: begin
            hdr_q <= hdr_nx;
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CW'(HW - 1)) begin
              cmd_q  <= cmd_nx;
              addr_q <= hdr_nx[AW-1:0];
              cnt_q  <= '0;
              if (cmd_nx == CMD_READ) begin
                state_q <= SEQ_RD;
                rd_sr_q <= {1'b0, rd_word_i};
              end else if (cmd_nx == CMD_WRITE || cmd_nx == CMD_WRALL) begin
                state_q <= SEQ_DATA;
              end else begin
                state_q <= SEQ_DONE;
              end
            end
          end
          SEQ_DATA: begin
            data_q <= {data_q[DW-2:0], di_i};
            cnt_q  <= cnt_q + 1'b1;
            if (cnt_q == CW'(DW - 1)) state_q <= SEQ_DONE;
          end
          SEQ_RD:   rd_sr_q <= {rd_sr_q[DW-1:0], 1'b0};
          SEQ_DONE: state_q <= SEQ_OVER;
          default:  state_q <= SEQ_OVER;
        endcase
      end
    end
  end

  assign start_o  = start_q;
  assign exec_o   = exec_q;
  assign cmd_o    = cmd_q;
  assign addr_o   = addr_q;
  assign data_o   = data_q;
  assign rd_act_o = (state_q == SEQ_RD);
  assign rd_bit_o = rd_sr_q[DW];

  // R2
  dummy_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_act_o) |-> !rd_bit_o);
  // R11
  exec_after_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_o |-> $past(state_q == SEQ_DONE));
endmodule

// File: rtl/mw_prog_timer.sv
module mw_prog_timer #(
  parameter int PROG_CYCLES = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int TW = $clog2(PROG_CYCLES + 1);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (start_i)         cnt_q <= TW'(PROG_CYCLES);
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end
  assign busy_o = (cnt_q != '0);

  // R10
  no_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_o);
  // R7
  busy_after_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_o);
endmodule

// File: rtl/mw_regfile.sv
module mw_regfile #(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_one_i,
  input  logic          we_all_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem_q [DEPTH];

  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   mem_q[w] <= '0;
      else if (we_all_i)                             mem_q[w] <= wdata_i;
      else if (we_one_i && waddr_i == AW'(w))        mem_q[w] <= wdata_i;
    end
  end
  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/mw_eeprom_slave.sv
module mw_eeprom_slave
  import mw_pkg::*;
#(
  parameter int AW          = 6,
  parameter int DW          = 16,
  parameter int PROG_CYCLES = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_i,
  input  logic sk_i,
  input  logic di_i,
  output logic do_o,
  output logic do_oe_o
);
  logic [2:0] lvl, rise;
  logic       cs_s, sk_rise, di_s;

  mw_sync_edge #(.N(3)) i_sync (
    .clk_i, .rst_ni,
    .raw_i  ({di_i, sk_i, cs_i}),
    .lvl_o  (lvl),
    .rise_o (rise)
  );
  assign cs_s    = lvl[0];
  assign sk_rise = rise[1];
  assign di_s    = lvl[2];

  logic          busy, start, exec, rd_act, rd_bit;
  cmd_e          cmd;
  logic [AW-1:0] addr, rd_addr;
  logic [DW-1:0] data, rd_word;

  mw_frame_dec #(.AW(AW), .DW(DW)) i_dec (
    .clk_i, .rst_ni,
    .cs_i      (cs_s),
    .sk_rise_i (sk_rise),
    .di_i      (di_s),
    .busy_i    (busy),
    .rd_word_i (rd_word),
    .rd_addr_o (rd_addr),
    .start_o   (start),
    .exec_o    (exec),
    .cmd_o     (cmd),
    .addr_o    (addr),
    .data_o    (data),
    .rd_act_o  (rd_act),
    .rd_bit_o  (rd_bit)
  );

  logic wen_q, status_q, do_q, oe_q;
  logic is_prog, prog_go, we_one, we_all, erase;

  assign is_prog = (cmd == CMD_WRITE) || (cmd == CMD_ERASE) ||
                   (cmd == CMD_WRALL) || (cmd == CMD_ERALL);
  assign prog_go = exec && wen_q && is_prog;
  assign erase   = (cmd == CMD_ERASE) || (cmd == CMD_ERALL);
  assign we_one  = prog_go && (cmd == CMD_WRITE || cmd == CMD_ERASE);
  assign we_all  = prog_go && (cmd == CMD_WRALL || cmd == CMD_ERALL);

  mw_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) i_timer (
    .clk_i, .rst_ni,
    .start_i (prog_go),
    .busy_o  (busy)
  );

  mw_regfile #(.AW(AW), .DW(DW)) i_mem (
    .clk_i, .rst_ni,
    .we_one_i (we_one),
    .we_all_i (we_all),
    .waddr_i  (addr),
    .wdata_i  (erase ? {DW{1'b1}} : data),
    .raddr_i  (rd_addr),
    .rdata_o  (rd_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wen_q    <= 1'b0;
      status_q <= 1'b0;
      do_q     <= 1'b0;
      oe_q     <= 1'b0;
    end else begin
      if (exec && cmd == CMD_WEN) wen_q <= 1'b1;
      if (exec && cmd == CMD_WDS) wen_q <= 1'b0;
      if (prog_go)    status_q <= 1'b1;
      else if (start) status_q <= 1'b0;
      oe_q <= cs_s && (status_q || rd_act);
      do_q <= status_q ? ~busy : rd_bit;
    end
  end

  assign do_o    = do_q;
  assign do_oe_o = oe_q;

  // R8
  oe_follows_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_s |=> !do_oe_o);
  // R4
  prog_needs_wen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> wen_q);
endmodule

// File: tb/test_mw_eeprom_slave.sv
module test_mw_eeprom_slave;
  localparam int  CLK_NS = 10;
  localparam int  HALF   = 80;
  localparam int  PROG   = 200;
  localparam int  K_WRITE = 1, K_ERASE = 2, K_WEN = 3, K_WDS = 4, K_WRALL = 5, K_ERALL = 6;

  logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sk = 1'b0, di = 1'b0;
  logic do_w, do_oe;
  int   checks = 0, failures = 0;
  bit   done = 0;

  always #(CLK_NS/2) clk = ~clk;

  mw_eeprom_slave #(.AW(6), .DW(16), .PROG_CYCLES(PROG)) i_mw_eeprom_slave (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .sk_i(sk), .di_i(di),
    .do_o(do_w), .do_oe_o(do_oe)
  );

  // {kind, addr, data, read addr, expected}
  localparam logic [46:0] VEC [11] = '{
    {3'd3, 6'd0,  16'h0000, 6'd5,  16'h0000},
    {3'd1, 6'd5,  16'hA5C3, 6'd5,  16'hA5C3},
    {3'd1, 6'd63, 16'h1234, 6'd63, 16'h1234},
    {3'd2, 6'd5,  16'h0000, 6'd5,  16'hFFFF},
    {3'd5, 6'd0,  16'h0F0F, 6'd20, 16'h0F0F},
    {3'd1, 6'd0,  16'h8001, 6'd0,  16'h8001},
    {3'd6, 6'd0,  16'h0000, 6'd63, 16'hFFFF},
    {3'd1, 6'd10, 16'hBEEF, 6'd10, 16'hBEEF},
    {3'd4, 6'd0,  16'h0000, 6'd10, 16'hBEEF},
    {3'd1, 6'd10, 16'h0000, 6'd10, 16'hBEEF},
    {3'd2, 6'd10, 16'h0000, 6'd10, 16'hBEEF}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clk_bit(input logic b, output logic o);
    di = b;
    #(HALF);
    o  = do_w;
    sk = 1'b1;
    #(HALF);
    sk = 1'b0;
  endtask

  task automatic cs_up();
    cs = 1'b1;
    #(HALF);
  endtask

  task automatic cs_down();
    cs = 1'b0;
    di = 1'b0;
    #(4*HALF);
  endtask

  task automatic send_bits(input logic [24:0] bits, input int n);
    logic o;
    for (int i = n - 1; i >= 0; i--) clk_bit(bits[i], o);
  endtask

  // returns frame bits and length for a command
  task automatic build(input int kind, input logic [5:0] a, input logic [15:0] d,
                       output logic [24:0] fr, output int n);
    logic [1:0] op;
    logic [5:0] ad;
    logic       has_d;
    has_d = 1'b0;
    ad    = a;
    case (kind)
      K_WRITE: begin op = 2'b01; has_d = 1'b1; end
      K_ERASE: op = 2'b11;
      K_WEN:   begin op = 2'b00; ad = 6'b110101; end
      K_WDS:   begin op = 2'b00; ad = 6'b001010; end
      K_WRALL: begin op = 2'b00; ad = 6'b011001; has_d = 1'b1; end
      default: begin op = 2'b00; ad = 6'b100110; end
    endcase
    if (has_d) begin fr = {1'b1, op, ad, d}; n = 25; end
    else       begin fr = {16'h0, 1'b1, op, ad}; n = 9; end
  endtask

  task automatic send_cmd(input int kind, input logic [5:0] a, input logic [15:0] d,
                          input int extra, input int cut);
    logic [24:0] fr;
    int          n;
    logic        o;
    build(kind, a, d, fr, n);
    cs_up();
    if (cut > 0) begin
      for (int i = n - 1; i >= n - cut; i--) clk_bit(fr[i], o);
    end else begin
      send_bits(fr, n);
      for (int i = 0; i < extra; i++) clk_bit(1'b0, o);
    end
    cs_down();
  endtask

  task automatic read_body(input logic [5:0] a, output logic [15:0] w,
                           output logic dummy, output logic oe_all);
    logic o;
    send_bits({16'h0, 3'b110, a}, 8);
    oe_all = 1'b1;
    clk_bit(1'b0, dummy);
    for (int i = 15; i >= 0; i--) begin
      clk_bit(1'b0, o);
      w[i] = o;
      oe_all &= do_oe;
    end
  endtask

  task automatic read_word(input logic [5:0] a, input int lead,
                           output logic [15:0] w, output logic dummy, output logic oe_all);
    logic o;
    cs_up();
    for (int i = 0; i < lead; i++) clk_bit(1'b0, o);
    clk_bit(1'b1, o);
    read_body(a, w, dummy, oe_all);
    cs_down();
  endtask

  task automatic wait_prog();
    #((PROG + 40) * CLK_NS);
  endtask

  initial begin
    #((100 * HALF) + (200000 * CLK_NS) - (100 * HALF));
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] w;
    logic        dm, oe_all, o;
    #2;
    #(5*CLK_NS);
    rst_n = 1'b1;
    #(4*CLK_NS);
    check("R3 oe after reset", 32'(do_oe), 0);

    // R3 disabled after reset: write must not land
    send_cmd(K_WRITE, 6'd2, 16'hDEAD, 0, 0);
    wait_prog();
    read_word(6'd2, 0, w, dm, oe_all);
    check("R3 write ignored before enable", 32'(w), 32'h0);

    for (int v = 0; v < 11; v++) begin
      send_cmd(int'(VEC[v][46:44]), VEC[v][43:38], VEC[v][37:22], 0, 0);
      wait_prog();
      read_word(VEC[v][21:16], 0, w, dm, oe_all);
      // R1 R4 R5 R6 R12 by table entry
      check($sformatf("R5/R6/R4/R12 vec%0d data", v), 32'(w), 32'(VEC[v][15:0]));
      check($sformatf("R2 vec%0d dummy", v), 32'(dm), 0);
      check($sformatf("R2 vec%0d oe", v), 32'(oe_all), 1);
    end

    // R7 status and R9 start bit clears ready and opens READ
    send_cmd(K_WEN, 6'd0, 16'h0, 0, 0);
    send_cmd(K_WRITE, 6'd3, 16'h5555, 0, 0);
    cs = 1'b1;
    #(8*CLK_NS);
    check("R7 busy oe", 32'(do_oe), 1);
    check("R7 busy level", 32'(do_w), 0);
    cs = 1'b0; #(10*CLK_NS); cs = 1'b1; #(10*CLK_NS);
    cs = 1'b0; #(10*CLK_NS); cs = 1'b1; #(10*CLK_NS);
    check("R8 oe after cs toggle", 32'(do_oe), 1);
    wait_prog();
    check("R7 ready level", 32'(do_w), 1);
    clk_bit(1'b1, o);
    clk_bit(1'b1, o);
    check("R9 ready cleared oe", 32'(do_oe), 0);
    send_bits({16'h0, 2'b10, 6'd3}, 7);
    oe_all = 1'b1;
    clk_bit(1'b0, dm);
    for (int i = 15; i >= 0; i--) begin
      clk_bit(1'b0, o);
      w[i] = o;
    end
    cs_down();
    check("R9 read in same cs period", 32'(w), 32'h5555);
    check("R9 dummy", 32'(dm), 0);
    check("R8 oe low with cs low", 32'(do_oe), 0);

    // R10 frame during busy ignored
    send_cmd(K_WRITE, 6'd4, 16'h1111, 0, 0);
    send_cmd(K_ERASE, 6'd4, 16'h0, 0, 0);
    wait_prog();
    read_word(6'd4, 0, w, dm, oe_all);
    check("R10 erase during busy ignored", 32'(w), 32'h1111);

    // R11 truncated frame
    send_cmd(K_WRITE, 6'd6, 16'h1357, 0, 19);
    cs = 1'b1;
    #(8*CLK_NS);
    check("R11 no status after truncated", 32'(do_oe), 0);
    cs_down();
    read_word(6'd6, 0, w, dm, oe_all);
    check("R11 truncated write no effect", 32'(w), 32'hFFFF);

    // R11 extra serial clocks
    send_cmd(K_WRITE, 6'd6, 16'h1357, 1, 0);
    wait_prog();
    read_word(6'd6, 0, w, dm, oe_all);
    check("R11 extra edge write no effect", 32'(w), 32'hFFFF);

    // R1 leading zeros before start bit
    read_word(6'd3, 3, w, dm, oe_all);
    check("R1 leading zeros read", 32'(w), 32'h5555);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule